// File: doc/BRIEF.md
# Immediate Interrupt Packet Filter

This block looks at the metadata of each received packet and decides whether the packet must raise an interrupt at once, without waiting for the normal moderation timer to expire. Each packet arrives as a one-cycle descriptor. The descriptor carries:

- a TCP flag
- the destination port
- the length
- the TCP control flags
- a VLAN-tag flag and the VLAN priority
- drop and error status

Eight programmable port-filter entries are held in the block, together with a VLAN priority control word. Both are loaded through a simple write port. The port filters check three things: the destination port, the packet size and the control flags. Any of the three checks can be bypassed in an entry. The result of each enabled entry is ORed with the others. A separate VLAN priority path can also trigger an interrupt without regard to the port filters.

A positive decision produces two outputs on the same cycle:

- a one-cycle immediate-interrupt pulse
- a one-cycle clear strobe that forces the downstream moderation counter to zero

Parsing of packets, the moderation counter itself and delivery of the interrupt are handled elsewhere.

Top module: `imm_irq_filter`

## Requirements
- R1: After reset, `irq_o` and `mod_clr_o` are low, every filter entry is disabled and VLAN filtering is off, so no packet raises an interrupt until the block is programmed.
- R2: The decision for a descriptor sampled with `pkt_valid_i` high appears on `irq_o` and `mod_clr_o` together, as a one-cycle pulse on the cycle after that edge. Back-to-back descriptors give back-to-back pulses. A cycle with `pkt_valid_i` low produces no pulse.
- R3: The port criterion of an entry matches when `pkt_dport_i` equals the entry's port field.
- R4: The size criterion matches when `pkt_len_i` is strictly less than the entry's size field.
- R5: The control criterion matches when at least one bit of `pkt_flags_i` that is set in the entry's flag mask is also set. A zero mask that is not bypassed never matches.
- R6: Each of the three criteria has its own bypass bit. A bypassed criterion always matches.
- R7: An entry matches only when its enable bit is set and all three of its criteria match. An interrupt is raised if any one entry matches.
- R8: The port filters act only on descriptors with `pkt_tcp_i` high.
- R9: When the VLAN enable bit is set, a descriptor with `pkt_vlan_i` high and `pkt_prio_i` greater than or equal to the 3-bit threshold raises an interrupt, whatever the port filters decide. Untagged packets, and all packets while VLAN filtering is disabled, never take this path.
- R10: A descriptor with `pkt_drop_i` or `pkt_err_i` high never raises an interrupt.
- R11: A configuration write in the same cycle as a descriptor does not affect that descriptor. It applies from the next descriptor onwards.
- R12: Write addresses and data layout:
  - Address k (0..7) loads entry k with this layout: bit 0 enable, bit 1 bypass port, bit 2 bypass size, bit 3 bypass flags, bits 9:4 flag mask, bits 25:10 port, bits 39:26 size threshold.
  - Address 8 loads the VLAN word: bit 0 enable, bits 3:1 threshold.
  - Writes to any other address have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration word address |
| cfg_wdata_i | input | 40 | Configuration write data |
| pkt_valid_i | input | 1 | Descriptor valid strobe, one cycle per packet |
| pkt_tcp_i | input | 1 | Packet is TCP |
| pkt_dport_i | input | 16 | TCP destination port |
| pkt_len_i | input | 14 | Packet length |
| pkt_flags_i | input | 6 | TCP control flags |
| pkt_vlan_i | input | 1 | Packet carries a VLAN tag |
| pkt_prio_i | input | 3 | VLAN priority |
| pkt_drop_i | input | 1 | Packet was dropped |
| pkt_err_i | input | 1 | Packet has an error |
| irq_o | output | 1 | Immediate interrupt pulse |
| mod_clr_o | output | 1 | Moderation counter clear strobe |

## Verification
Every decision is due exactly one cycle after the clock edge that samples its descriptor. Both outputs come from a single register stage. The driver records the cycle number at which each expected result falls due and pushes it onto a queue. The monitor compares results at the falling edge of that cycle, so it never samples at an edge where the output is changing.

Configuration writes go through the same driver. The bench can therefore place a write in the same cycle as a packet and check that the old table still decides that packet. Rejections are checked in the same way, by expecting a low output on the due cycle. This covers disabled entries, writes to unused addresses, and dropped or errored packets.

// File: rtl/imm_irq_pkg.sv
package imm_irq_pkg;
  // control bit positions inside an entry word
  localparam int unsigned EN_BIT     = 0;
  localparam int unsigned BYP_PORT   = 1;
  localparam int unsigned BYP_SIZE   = 2;
  localparam int unsigned BYP_FLAGS  = 3;
  localparam int unsigned CTRL_BITS  = 4;
endpackage

// File: rtl/imm_irq_cfg.sv
module imm_irq_cfg #(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned ENTRY_W     = 40,
  parameter int unsigned PRIO_W      = 3,
  parameter int unsigned ADDR_W      = 4
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                we_i,
  input  logic [ADDR_W-1:0]                   addr_i,
  input  logic [ENTRY_W-1:0]                  wdata_i,
  output logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entry_o,
  output logic                                vlan_en_o,
  output logic [PRIO_W-1:0]                   vlan_thr_o
);
  localparam logic [ADDR_W-1:0] VLAN_ADDR = ADDR_W'(NUM_ENTRIES);

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 entry_o[g] <= '0;
      else if (we_i && addr_i == ADDR_W'(g))       entry_o[g] <= wdata_i;
    end

    // R12
    wr_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (we_i && addr_i == ADDR_W'(g)) |=> (entry_o[g] == $past(wdata_i)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vlan_en_o  <= 1'b0;
      vlan_thr_o <= '0;
    end else if (we_i && addr_i == VLAN_ADDR) begin
      vlan_en_o  <= wdata_i[0];
      vlan_thr_o <= wdata_i[PRIO_W:1];
    end
  end

  // R12
  wr_vlan_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == VLAN_ADDR) |=> (vlan_thr_o == $past(wdata_i[PRIO_W:1])));
endmodule

// File: rtl/imm_irq_entry.sv
module imm_irq_entry
  import imm_irq_pkg::*;
#(
  parameter int unsigned PORT_W  = 16,
  parameter int unsigned LEN_W   = 14,
  parameter int unsigned FLAG_W  = 6,
  localparam int unsigned ENTRY_W = CTRL_BITS + FLAG_W + PORT_W + LEN_W
) (
  input  logic [ENTRY_W-1:0] cfg_i,
  input  logic [PORT_W-1:0]  dport_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [FLAG_W-1:0]  flags_i,
  output logic               hit_o
);
  localparam int unsigned MASK_LO = CTRL_BITS;
  localparam int unsigned PORT_LO = MASK_LO + FLAG_W;
  localparam int unsigned SIZE_LO = PORT_LO + PORT_W;

  logic [FLAG_W-1:0] mask;
  logic [PORT_W-1:0] port;
  logic [LEN_W-1:0]  size_thr;
  logic              port_ok, size_ok, flag_ok;

  assign mask     = cfg_i[MASK_LO +: FLAG_W];
  assign port     = cfg_i[PORT_LO +: PORT_W];
  assign size_thr = cfg_i[SIZE_LO +: LEN_W];

  assign port_ok = cfg_i[BYP_PORT]  || (dport_i == port);
  assign size_ok = cfg_i[BYP_SIZE]  || (len_i < size_thr);
  assign flag_ok = cfg_i[BYP_FLAGS] || (|(flags_i & mask));

  assign hit_o = cfg_i[EN_BIT] && port_ok && size_ok && flag_ok;
endmodule

// File: rtl/imm_irq_vlan.sv
module imm_irq_vlan #(
  parameter int unsigned PRIO_W = 3
) (
  input  logic              en_i,
  input  logic              tagged_i,
  input  logic [PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0] thr_i,
  output logic              hit_o
);
  assign hit_o = en_i && tagged_i && (prio_i >= thr_i);
endmodule

// File: rtl/imm_irq_filter.sv
module imm_irq_filter
  import imm_irq_pkg::*;
#(
  parameter int unsigned NUM_ENTRIES = 8,
  parameter int unsigned PORT_W      = 16,
  parameter int unsigned LEN_W       = 14,
  parameter int unsigned FLAG_W      = 6,
  parameter int unsigned PRIO_W      = 3,
  localparam int unsigned ENTRY_W    = CTRL_BITS + FLAG_W + PORT_W + LEN_W,
  localparam int unsigned ADDR_W     = $clog2(NUM_ENTRIES + 1)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cfg_we_i,
  input  logic [ADDR_W-1:0]  cfg_addr_i,
  input  logic [ENTRY_W-1:0] cfg_wdata_i,
  input  logic               pkt_valid_i,
  input  logic               pkt_tcp_i,
  input  logic [PORT_W-1:0]  pkt_dport_i,
  input  logic [LEN_W-1:0]   pkt_len_i,
  input  logic [FLAG_W-1:0]  pkt_flags_i,
  input  logic               pkt_vlan_i,
  input  logic [PRIO_W-1:0]  pkt_prio_i,
  input  logic               pkt_drop_i,
  input  logic               pkt_err_i,
  output logic               irq_o,
  output logic               mod_clr_o
);
  logic [NUM_ENTRIES-1:0][ENTRY_W-1:0] entry_q;
  logic                                vlan_en_q;
  logic [PRIO_W-1:0]                   vlan_thr_q;
  logic [NUM_ENTRIES-1:0]              entry_hit;
  logic                                vlan_hit, port_hit, fire_d, fire_q;

  imm_irq_cfg #(
    .NUM_ENTRIES(NUM_ENTRIES),
    .ENTRY_W    (ENTRY_W),
    .PRIO_W     (PRIO_W),
    .ADDR_W     (ADDR_W)
  ) i_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (cfg_we_i),
    .addr_i    (cfg_addr_i),
    .wdata_i   (cfg_wdata_i),
    .entry_o   (entry_q),
    .vlan_en_o (vlan_en_q),
    .vlan_thr_o(vlan_thr_q)
  );

  for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_flt
    imm_irq_entry #(
      .PORT_W(PORT_W),
      .LEN_W (LEN_W),
      .FLAG_W(FLAG_W)
    ) i_entry (
      .cfg_i  (entry_q[g]),
      .dport_i(pkt_dport_i),
      .len_i  (pkt_len_i),
      .flags_i(pkt_flags_i),
      .hit_o  (entry_hit[g])
    );
  end

  imm_irq_vlan #(.PRIO_W(PRIO_W)) i_vlan (
    .en_i    (vlan_en_q),
    .tagged_i(pkt_vlan_i),
    .prio_i  (pkt_prio_i),
    .thr_i   (vlan_thr_q),
    .hit_o   (vlan_hit)
  );

  assign port_hit = pkt_tcp_i && (|entry_hit);
  assign fire_d   = pkt_valid_i && !pkt_drop_i && !pkt_err_i && (port_hit || vlan_hit);

  // config registers update on the same edge, so this packet sees the old table
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fire_q <= 1'b0;
    else         fire_q <= fire_d;
  end

  assign irq_o     = fire_q;
  assign mod_clr_o = fire_q;

  // R2
  no_idle_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pkt_valid_i |=> !irq_o);

  // R10
  no_bad_pkt_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && (pkt_drop_i || pkt_err_i)) |=> !irq_o);

  // R9
  vlan_fire_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_drop_i && !pkt_err_i && vlan_en_q && pkt_vlan_i &&
     pkt_prio_i >= vlan_thr_q) |=> (irq_o && mod_clr_o));

  // R8
  non_tcp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && !pkt_tcp_i && !(vlan_en_q && pkt_vlan_i)) |=> !irq_o);

  // R7
  any_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pkt_valid_i && pkt_tcp_i && !pkt_drop_i && !pkt_err_i && (|entry_hit)) |=> irq_o);
endmodule

// File: tb/test_imm_irq_filter.sv
module test_imm_irq_filter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [39:0] cfg_wdata = '0;
  logic        pkt_valid = 1'b0, pkt_tcp = 1'b0, pkt_vlan = 1'b0, pkt_drop = 1'b0, pkt_err = 1'b0;
  logic [15:0] pkt_dport = '0;
  logic [13:0] pkt_len = '0;
  logic [5:0]  pkt_flags = '0;
  logic [2:0]  pkt_prio = '0;
  logic        irq, mod_clr;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  typedef struct {int due; bit exp; string tag;} item_t;
  item_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  imm_irq_filter i_imm_irq_filter (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .pkt_valid_i(pkt_valid), .pkt_tcp_i(pkt_tcp), .pkt_dport_i(pkt_dport),
    .pkt_len_i(pkt_len), .pkt_flags_i(pkt_flags), .pkt_vlan_i(pkt_vlan),
    .pkt_prio_i(pkt_prio), .pkt_drop_i(pkt_drop), .pkt_err_i(pkt_err),
    .irq_o(irq), .mod_clr_o(mod_clr)
  );

  function automatic logic [39:0] ent(bit en, bit bp, bit bs, bit bf,
                                      logic [5:0] mask, logic [15:0] port, logic [13:0] size);
    return {size, port, mask, bf, bs, bp, en};
  endfunction

  task automatic check(bit act_irq, bit act_clr, bit exp, string tag);
    total++;
    if (act_irq !== exp || act_clr !== exp) begin
      bad++;
      $display("FAIL %s: irq=%0b clr=%0b expected=%0b", tag, act_irq, act_clr, exp);
    end
  endtask

  // monitor: compare each result on its due cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due == cyc) begin
      item_t it;
      it = q.pop_front();
      check(irq, mod_clr, it.exp, it.tag);
    end
  end

  task automatic drive_pkt(bit v, bit tcp, logic [15:0] port, logic [13:0] len,
                           logic [5:0] fl, bit vl, logic [2:0] pr, bit dr, bit er);
    pkt_valid = v; pkt_tcp = tcp; pkt_dport = port; pkt_len = len;
    pkt_flags = fl; pkt_vlan = vl; pkt_prio = pr; pkt_drop = dr; pkt_err = er;
  endtask

  task automatic send(bit v, bit tcp, logic [15:0] port, logic [13:0] len,
                      logic [5:0] fl, bit vl, logic [2:0] pr, bit dr, bit er,
                      bit exp, string tag);
    @(negedge clk);
    cfg_we = 1'b0;
    drive_pkt(v, tcp, port, len, fl, vl, pr, dr, er);
    q.push_back('{due: cyc + 1, exp: exp, tag: tag});
  endtask

  task automatic wr(logic [3:0] a, logic [39:0] d);
    @(negedge clk);
    pkt_valid = 1'b0;
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
  endtask

  task automatic idle(int n);
    repeat (n) begin
      @(negedge clk);
      pkt_valid = 1'b0; cfg_we = 1'b0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(irq, mod_clr, 1'b0, "R1 reset outputs");
    rst_n = 1'b1;
    // R1: unprogrammed table, catch-all TCP packet
    send(1, 1, 16'd80, 14'd10, 6'h3f, 1, 3'd7, 0, 0, 0, "R1 nothing enabled");

    // R3 port criterion
    wr(4'd0, ent(1, 0, 1, 1, 6'h00, 16'd80, 14'd0));
    send(1, 1, 16'd80, 14'd500, 6'h00, 0, 0, 0, 0, 1, "R3 port equal");
    send(1, 1, 16'd81, 14'd500, 6'h00, 0, 0, 0, 0, 0, "R3 port differs");
    // R4 size strictly less
    wr(4'd0, ent(1, 1, 0, 1, 6'h00, 16'd0, 14'd64));
    send(1, 1, 16'd9, 14'd63, 6'h00, 0, 0, 0, 0, 1, "R4 len below");
    send(1, 1, 16'd9, 14'd64, 6'h00, 0, 0, 0, 0, 0, "R4 len equal");
    // R5 any selected flag
    wr(4'd0, ent(1, 1, 1, 0, 6'h09, 16'd0, 14'd0));
    send(1, 1, 16'd9, 14'd5, 6'h08, 0, 0, 0, 0, 1, "R5 flag in mask");
    send(1, 1, 16'd9, 14'd5, 6'h06, 0, 0, 0, 0, 0, "R5 flags outside mask");
    wr(4'd0, ent(1, 1, 1, 0, 6'h00, 16'd0, 14'd0));
    send(1, 1, 16'd9, 14'd5, 6'h3f, 0, 0, 0, 0, 0, "R5 zero mask");
    // R6 all bypassed
    wr(4'd0, ent(1, 1, 1, 1, 6'h00, 16'd1, 14'd0));
    send(1, 1, 16'd1234, 14'd9000, 6'h00, 0, 0, 0, 0, 1, "R6 all bypass");
    // R8 non-TCP
    send(1, 0, 16'd1234, 14'd9000, 6'h00, 0, 0, 0, 0, 0, "R8 non tcp");
    // R2 back to back, then an invalid cycle
    send(1, 1, 16'd1, 14'd1, 6'h00, 0, 0, 0, 0, 1, "R2 back to back a");
    send(1, 1, 16'd2, 14'd1, 6'h00, 0, 0, 0, 0, 1, "R2 back to back b");
    send(0, 1, 16'd2, 14'd1, 6'h00, 0, 0, 0, 0, 0, "R2 valid low");
    // R7 enable and OR across entries
    wr(4'd0, ent(0, 1, 1, 1, 6'h00, 16'd0, 14'd0));
    send(1, 1, 16'd443, 14'd1, 6'h00, 0, 0, 0, 0, 0, "R7 entry disabled");
    wr(4'd5, ent(1, 0, 1, 1, 6'h00, 16'd443, 14'd0));
    send(1, 1, 16'd443, 14'd1, 6'h00, 0, 0, 0, 0, 1, "R7 entry 5 hit");
    send(1, 1, 16'd80, 14'd1, 6'h00, 0, 0, 0, 0, 0, "R7 no entry hit");
    // R10 drop / error
    send(1, 1, 16'd443, 14'd1, 6'h00, 0, 0, 1, 0, 0, "R10 dropped");
    send(1, 1, 16'd443, 14'd1, 6'h00, 0, 0, 0, 1, 0, "R10 errored");
    // R9 VLAN path
    wr(4'd8, 40'h4 << 1 | 40'h1);
    send(1, 0, 16'd0, 14'd1, 6'h00, 1, 3'd4, 0, 0, 1, "R9 prio equal thr");
    send(1, 0, 16'd0, 14'd1, 6'h00, 1, 3'd3, 0, 0, 0, "R9 prio below thr");
    send(1, 0, 16'd0, 14'd1, 6'h00, 1, 3'd7, 0, 0, 1, "R9 prio above thr");
    send(1, 1, 16'd80, 14'd1, 6'h00, 1, 3'd7, 0, 0, 1, "R9 overrides port miss");
    send(1, 0, 16'd0, 14'd1, 6'h00, 0, 3'd7, 0, 0, 0, "R9 untagged");
    send(1, 0, 16'd0, 14'd1, 6'h00, 1, 3'd7, 1, 0, 0, "R10 vlan dropped");
    wr(4'd8, 40'h4 << 1);
    send(1, 0, 16'd0, 14'd1, 6'h00, 1, 3'd7, 0, 0, 0, "R9 vlan disabled");
    // R11 write coincident with packet
    @(negedge clk);
    drive_pkt(1, 1, 16'd22, 14'd1, 6'h00, 0, 0, 0, 0);
    cfg_we = 1'b1; cfg_addr = 4'd5; cfg_wdata = ent(1, 0, 1, 1, 6'h00, 16'd22, 14'd0);
    q.push_back('{due: cyc + 1, exp: 1'b0, tag: "R11 same cycle write"});
    send(1, 1, 16'd22, 14'd1, 6'h00, 0, 0, 0, 0, 1, "R11 next packet new port");
    send(1, 1, 16'd443, 14'd1, 6'h00, 0, 0, 0, 0, 0, "R11 old port gone");
    // R12 addressing
    wr(4'd3, ent(1, 0, 1, 1, 6'h00, 16'd1000, 14'd0));
    send(1, 1, 16'd1000, 14'd1, 6'h00, 0, 0, 0, 0, 1, "R12 entry 3 loaded");
    wr(4'd9, ent(1, 1, 1, 1, 6'h00, 16'd0, 14'd0));
    wr(4'd15, 40'hff_ffff_ffff);
    send(1, 1, 16'd7, 14'd0, 6'h00, 1, 3'd7, 0, 0, 0, "R12 unused address");

    idle(4);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule